// File: doc/BRIEF.md
# Circular-Queue Operand Address Masker

This block forms the bus address for each operand fetch of a multiply-accumulate unit. It can also keep a walking pointer inside a power-of-two-aligned ring buffer. Software programs a 16-bit mask through a small register port. The register reads back as a 32-bit word whose upper half is always ones.

For each request the block takes the current value of an address register. When bit 5 of the instruction extension word is set, it clears every address bit whose mask bit is zero. It then adds the access size to produce the post-incremented pointer. That pointer is masked again, so it wraps inside the region.

Both the final bus address and the updated pointer are registered. A valid strobe marks them one cycle after the request.

Top module: `cq_addr_mask`

## Requirements
- R1: A register write keeps only bits 15:0 of `reg_wr_data`. From the next cycle, `reg_rd_data` returns those 16 bits in bits 15:0 and ones in bits 31:16.
- R2: After reset, `reg_rd_data` is 32'hFFFF_FFFF, `out_valid` is 0, and `out_addr` and `out_next` are 0.
- R3: When `req_ext` bit 5 is 1, `out_addr` equals `req_base` ANDed with `{16'hFFFF, mask}`.
- R4: When `req_ext` bit 5 is 0, `out_addr` equals `req_base` unchanged. No other bit of `req_ext` changes any output.
- R5: `req_size` selects the post-increment step:
  - 2'b00 gives 1.
  - 2'b01 gives 2.
  - 2'b10 and 2'b11 give 4.
- R6: With masking enabled, `out_next` is `(out_addr + step) & {16'hFFFF, mask}`, so a pointer fed back wraps inside the aligned region. With masking disabled, `out_next` is `req_base + step` modulo 2^32.
- R7: A request in the same cycle as a register write uses the mask that was stored before that write.
- R8: `out_valid` is high exactly one cycle after each cycle with `req_valid` high. `out_addr` and `out_next` change only in that cycle and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Mask register write strobe |
| reg_wr_data | input | 32 | Write data; only bits 15:0 are kept |
| reg_rd_data | output | 32 | Mask register read value, upper half ones |
| req_valid | input | 1 | Operand access request |
| req_base | input | 32 | Current address register value |
| req_size | input | 2 | Access size code |
| req_ext | input | 16 | Instruction extension word; bit 5 enables masking |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_addr | output | 32 | Final operand bus address |
| out_next | output | 32 | Post-incremented address register value |

## Verification
On every cycle, the bound checker confirms several properties:
- the strobe timing;
- the hold of the outputs between requests;
- the read-back format after a write;
- the masked and unmasked address relations against the previous cycle's mask value, which also covers the old-mask rule for a simultaneous write;
- that a masked next pointer never sets a bit the mask clears.

Only the bench scenarios can show the following:
- the exact increment per size code, including the reserved code;
- the actual wrap sequence of a pointer fed back through a ring;
- the 32-bit carry-out of an unmasked increment;
- that unrelated extension bits are ignored.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    // Post-increment step in bytes for a size code.
    function automatic logic [2:0] size_step(input size_e sz);
        logic [2:0] step;
        case (sz)
            SZ_BYTE: step = 3'd1;
            SZ_HALF: step = 3'd2;
            default: step = 3'd4;
        endcase
        return step;
    endfunction

endpackage

// File: rtl/cq_mask_reg.sv
module cq_mask_reg #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] full_mask
);
    localparam int HI_W = ADDR_W - MASK_W;

    logic [MASK_W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_en) begin
            mask_d = wr_data[MASK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end

    // Upper half is hardwired to ones.
    assign full_mask = {{HI_W{1'b1}}, mask_q};

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[ADDR_W-1:MASK_W];

endmodule

// File: rtl/cq_ea_calc.sv
module cq_ea_calc #(
    parameter int ADDR_W = 32,
    parameter int EXT_W  = 16,
    parameter int EN_BIT = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        size,
    input  logic [EXT_W-1:0]  ext,
    input  logic [ADDR_W-1:0] full_mask,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] next
);
    localparam logic [EXT_W-1:0] EN_SEL = EXT_W'(1) << EN_BIT;

    logic              mask_en;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        mask_en = |(ext & EN_SEL);
        step    = ADDR_W'(cq_pkg::size_step(cq_pkg::size_e'(size)));
        addr    = mask_en ? (base & full_mask) : base;
        sum     = addr + step;
        next    = mask_en ? (sum & full_mask) : sum;
    end

endmodule

// File: rtl/cq_addr_mask.sv
module cq_addr_mask #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 16,
    parameter int EXT_W  = 16,
    parameter int EN_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_data,
    output logic [ADDR_W-1:0] reg_rd_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [1:0]        req_size,
    input  logic [EXT_W-1:0]  req_ext,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] out_next
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] next;
    } out_t;

    logic [ADDR_W-1:0] full_mask;
    logic [ADDR_W-1:0] calc_addr;
    logic [ADDR_W-1:0] calc_next;
    out_t              out_d, out_q;

    cq_mask_reg #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) mask_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .full_mask (full_mask)
    );

    cq_ea_calc #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .EN_BIT(EN_BIT)) calc_i (
        .base      (req_base),
        .size      (req_size),
        .ext       (req_ext),
        .full_mask (full_mask),
        .addr      (calc_addr),
        .next      (calc_next)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req_valid;
        if (req_valid) begin
            out_d.addr = calc_addr;
            out_d.next = calc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign reg_rd_data = full_mask;
    assign out_valid   = out_q.valid;
    assign out_addr    = out_q.addr;
    assign out_next    = out_q.next;

endmodule

// File: rtl/cq_addr_mask_chk.sv
module cq_addr_mask_chk #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 16,
    parameter int EXT_W  = 16,
    parameter int EN_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_wr_data,
    input logic [ADDR_W-1:0] reg_rd_data,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_base,
    input logic [EXT_W-1:0]  req_ext,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [ADDR_W-1:0] out_next
);
    localparam int HI_W = ADDR_W - MASK_W;

    // R8
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R8
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R8
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_addr) && $stable(out_next)));

    // R1
    readback_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data == {{HI_W{1'b1}}, $past(reg_wr_data[MASK_W-1:0])}));

    // R3 R7
    masked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ext[EN_BIT]) |=> (out_addr == ($past(req_base) & $past(reg_rd_data))));

    // R4
    pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ext[EN_BIT]) |=> (out_addr == $past(req_base)));

    // R6
    next_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ext[EN_BIT]) |=> ((out_next | $past(reg_rd_data)) == $past(reg_rd_data)));

endmodule

bind cq_addr_mask cq_addr_mask_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .req_valid   (req_valid),
    .req_base    (req_base),
    .req_ext     (req_ext),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_next    (out_next)
);

// File: tb/cq_addr_mask_tb.sv
`timescale 1ns/1ps
module cq_addr_mask_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic        req_valid;
    logic [31:0] req_base;
    logic [1:0]  req_size;
    logic [15:0] req_ext;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_next;

    always #4 clk = ~clk;

    cq_addr_mask dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .req_valid   (req_valid),
        .req_base    (req_base),
        .req_size    (req_size),
        .req_ext     (req_ext),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_next    (out_next)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    logic [15:0] m_mask;
    logic        e_valid;
    logic [31:0] e_addr;
    logic [31:0] e_next;

    function automatic logic [31:0] step_of(input logic [1:0] s);
        if (s == 2'b00) return 32'd1;
        if (s == 2'b01) return 32'd2;
        return 32'd4;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk("R8", "out_valid", {31'd0, out_valid}, {31'd0, e_valid});
        chk(tag, "out_addr", out_addr, e_addr);
        chk(tag, "out_next", out_next, e_next);
        chk("R1", "reg_rd_data", reg_rd_data, {16'hFFFF, m_mask});
    endtask

    task automatic step(input bit wr, input logic [31:0] wd, input bit v,
                        input logic [31:0] b, input logic [1:0] s,
                        input logic [15:0] x, input string tag);
        logic [31:0] fm;
        logic [31:0] a;
        logic [31:0] n;
        reg_wr_en   = wr;
        reg_wr_data = wd;
        req_valid   = v;
        req_base    = b;
        req_size    = s;
        req_ext     = x;
        if (v) begin
            fm = {16'hFFFF, m_mask};
            a  = x[5] ? (b & fm) : b;
            n  = a + step_of(s);
            if (x[5]) n = n & fm;
            e_addr = a;
            e_next = n;
        end
        e_valid = v;
        if (wr) m_mask = wd[15:0];
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] ptr;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0; req_valid = 1'b0;
        req_base = '0; req_size = '0; req_ext = '0;
        m_mask = 16'hFFFF; e_valid = 1'b0; e_addr = '0; e_next = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        chk("R2", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R2", "out_addr", out_addr, 32'd0);
        chk("R2", "out_next", out_next, 32'd0);
        chk("R2", "reg_rd_data", reg_rd_data, 32'hFFFF_FFFF);
        rst_n = 1'b1;

        // R3 reset mask leaves address unchanged
        step(0, 0, 1, 32'h1234_5677, 2'b00, 16'h0020, "R3");
        // R1 write keeps low half only
        step(1, 32'hABCD_1234, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R8");
        // R3 masked address, R5 half step
        step(0, 0, 1, 32'hFFFF_FFFF, 2'b01, 16'h0020, "R3");
        // R4 unmasked with every other extension bit set
        step(0, 0, 1, 32'h8000_FFFE, 2'b01, 16'hFFDF, "R4");
        // R5 each size code
        step(0, 0, 1, 32'h0000_1000, 2'b00, 16'h0000, "R5");
        step(0, 0, 1, 32'h0000_1000, 2'b10, 16'h0000, "R5");
        step(0, 0, 1, 32'h0000_1000, 2'b11, 16'h0000, "R5");
        // R6 unmasked carry out of 32 bits
        step(0, 0, 1, 32'hFFFF_FFFE, 2'b10, 16'h0000, "R6");
        // R7 write and request together use the old mask
        step(1, 32'h0000_103F, 1, 32'h5555_FFFF, 2'b10, 16'h0020, "R7");
        // R8 idle cycles hold outputs
        step(0, 0, 0, 32'hDEAD_BEEF, 2'b01, 16'h0020, "R8");
        step(0, 0, 0, 32'h0, 2'b00, 16'h0000, "R8");
        // R6 ring walk: 64-byte region at 0x1000, pointer fed back
        ptr = 32'h2000_1030;
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 1, ptr, 2'b10, 16'h0020, "R6");
            ptr = e_next;
        end
        chk("R6", "ring wrap ptr", ptr, 32'h2000_1010);
        // R6 byte ring with a tight 8-byte mask
        step(1, 32'hFFFF_FFF7, 0, 0, 0, 0, "R1");
        ptr = 32'h0000_0005;
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 1, ptr, 2'b00, 16'h0020, "R6");
            ptr = e_next;
        end
        chk("R6", "byte ring ptr", ptr, 32'h0000_0002);
        // Mixed traffic
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 8) == 0, $urandom, ($urandom % 4) != 0, $urandom,
                 2'($urandom), 16'($urandom), "R3");
        end
        reg_wr_en = 1'b0; req_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule